// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that runs Clause 22 frames to external PHYs. Software sees two 32-bit registers. The command word holds the operation, the PHY and register addresses, and the 16-bit write data. It also holds a start bit that reads back as busy for as long as a frame is running. When a read completes, the same word returns the captured data and a flag that reports a turnaround failure.

The configuration word sets the half-period of the management clock in reference-clock cycles, can skip the 32-bit preamble, and holds a clause-select bit. The block drives the management clock. It drives the data line through an output-enable pair, so that an external tri-state pad can release the line for the PHY's turnaround and read data. It samples the returned bits on rising clock edges.

Top module: `mdio_host`

## Requirements
- R1: After reset the command word (byte offset 0x0) reads 0, and the configuration word (byte offset 0x4) reads 0x311: divider 49 in bits 9:4 and clause select set in bit 0. The clock output is low and the output enable is low.
- R2: A command write with bit 29 set, accepted while idle, makes bit 29 read 1 from the next cycle. Bit 29 stays 1 for exactly S x 2 x (D+1) cycles, where D is the divider and S is 64 slots, or 32 slots with the preamble skipped.
- R3: The clock output rises first D+1 cycles after the start edge. Consecutive rising edges are 2 x (D+1) cycles apart. The clock stays low whenever no frame is running.
- R4: Each frame serializes, MSB first with the output enable high, these bits: 32 ones (unless skipped), then 01, then the opcode from bits 27:26, then the PHY address from bits 25:21, then the register address from bits 20:16.
- R5: With opcode 01 (write), the two turnaround slots carry 1 then 0. The 16 data bits from bits 15:0 follow MSB first, with the output enable held high.
- R6: With opcode 10 (read), the output enable is low for the two turnaround slots and the 16 data slots. Bits 15:0 of the command word hold the 16 values sampled on the data slots' rising clock edges, first sample in bit 15.
- R7: Bit 28 of the command word reads 1 after a read only if the data input was high at the rising edge of the second turnaround slot. A write frame leaves it 0.
- R8: Configuration bit 12 skips the 32 preamble slots, so the frame begins directly with the 01 start bits.
- R9: A command write while bit 29 reads 1 is ignored: the running frame's bits and the stored opcode and addresses are unaffected.
- R10: A command write with bit 29 clear stores the fields, which read back in place, and starts no frame.
- R11: The data output and output enable change only while the clock output is low. They never change during a high phase.
- R12: The configuration word reads back bits 12, 9:4 and 0 as written, and every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Byte offset: 0x0 command, 0x4 configuration |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for the addressed register (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line value to drive |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Data line as seen at the pad |

## Verification
Busy appears one edge after the start write. It falls exactly S x 2 x (D+1) edges later. The bench therefore counts the cycles during which busy reads 1 at falling reference-clock edges and compares that count with the product. Each rising edge of the management clock is timestamped in reference cycles. The first rising edge must fall D+1 cycles after the start, and each later one 2 x (D+1) cycles after the one before. The bit line and the enable are captured a moment after each rising edge. A model PHY changes its response just after each falling edge, so the design samples stable data on the next rising edge. Read data and the failure flag are read back once busy has cleared.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DIV_W       = 6;
  localparam int OP_W        = 2;
  localparam int PHY_W       = 5;
  localparam int REG_W       = 5;
  localparam int DATA_W      = 16;
  localparam int PRE_SLOTS   = 32;
  localparam int HDR_BITS    = 2 + OP_W + PHY_W + REG_W;
  localparam int TA_SLOT0    = PRE_SLOTS + HDR_BITS;
  localparam int TA_SLOT1    = TA_SLOT0 + 1;
  localparam int DATA_SLOT0  = TA_SLOT0 + 2;
  localparam int FRAME_SLOTS = DATA_SLOT0 + DATA_W;
  localparam int SLOT_W      = $clog2(FRAME_SLOTS);

  // command word layout
  localparam int START_BIT = 29;
  localparam int FAIL_BIT  = 28;
  localparam int OP_LSB    = 26;
  localparam int PHY_LSB   = 21;
  localparam int REG_LSB   = 16;
  // configuration word layout
  localparam int C22_BIT   = 0;
  localparam int DIV_LSB   = 4;
  localparam int NOPRE_BIT = 12;

  localparam int CMD_OFS = 0;
  localparam int CFG_OFS = 4;

  localparam logic [OP_W-1:0] OP_READ  = 2'b10;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

  typedef struct packed {
    logic sample;   // shift in one read bit
    logic taCheck;  // judge the second turnaround slot
  } strobe_t;
endpackage

// File: rtl/mdio_ctl.sv
module mdio_ctl
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [DIV_W-1:0]  divVal,
  input  logic              noPreamble,
  input  logic              startRead,
  output strobe_t           strb,
  output logic [SLOT_W-1:0] slot,
  output logic              running,
  output logic              mdc,
  output logic              mdioOe
);
  logic [DIV_W-1:0] halfCnt;
  logic [DIV_W-1:0] divLat;
  logic             readLat;
  logic             halfEnd;
  logic             lastSlot;

  assign halfEnd  = running && (halfCnt >= divLat);
  assign lastSlot = (slot == SLOT_W'(FRAME_SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      mdc     <= 1'b0;
      halfCnt <= '0;
      slot    <= '0;
      divLat  <= '0;
      readLat <= 1'b0;
    end else if (startPulse && !running) begin
      running <= 1'b1;
      mdc     <= 1'b0;
      halfCnt <= '0;
      divLat  <= divVal;
      readLat <= startRead;
      slot    <= noPreamble ? SLOT_W'(PRE_SLOTS) : '0;
    end else if (running) begin
      if (halfEnd) begin
        halfCnt <= '0;
        mdc     <= ~mdc;
        if (mdc) begin
          if (lastSlot) running <= 1'b0;
          else          slot    <= slot + SLOT_W'(1);
        end
      end else begin
        halfCnt <= halfCnt + DIV_W'(1);
      end
    end
  end

  always_comb begin
    strb.sample  = halfEnd && !mdc && readLat && (slot >= SLOT_W'(DATA_SLOT0));
    strb.taCheck = halfEnd && !mdc && readLat && (slot == SLOT_W'(TA_SLOT1));
    mdioOe       = running && !(readLat && (slot >= SLOT_W'(TA_SLOT0)));
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !mdc); // R3
  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (halfCnt <= divLat)); // R3
  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |=> mdc); // R6
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int RST_DIV = 49
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic              cfgWr,
  input  logic [31:0]       wrData,
  input  logic              running,
  input  strobe_t           strb,
  input  logic [SLOT_W-1:0] slot,
  input  logic              mdioIn,
  output logic              startPulse,
  output logic              startRead,
  output logic [DIV_W-1:0]  divVal,
  output logic              noPreamble,
  output logic              frameBit,
  output logic [31:0]       cmdWord,
  output logic [31:0]       cfgWord
);
  logic [OP_W-1:0]        opReg;
  logic [PHY_W-1:0]       phyReg;
  logic [REG_W-1:0]       regReg;
  logic [DATA_W-1:0]      dataReg;
  logic                   failReg;
  logic                   c22Reg;
  logic                   cmdAccept;
  logic [FRAME_SLOTS-1:0] frameImg;
  logic                   unusedBits;

  assign cmdAccept  = cmdWr && !running;
  assign startPulse = cmdAccept && wrData[START_BIT];
  assign startRead  = (wrData[OP_LSB +: OP_W] == OP_READ);
  assign unusedBits = ^{wrData[31:30], wrData[FAIL_BIT]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg      <= '0;
      phyReg     <= '0;
      regReg     <= '0;
      dataReg    <= '0;
      failReg    <= 1'b0;
      c22Reg     <= 1'b1;
      divVal     <= DIV_W'(RST_DIV);
      noPreamble <= 1'b0;
    end else begin
      if (cmdAccept) begin
        opReg   <= wrData[OP_LSB  +: OP_W];
        phyReg  <= wrData[PHY_LSB +: PHY_W];
        regReg  <= wrData[REG_LSB +: REG_W];
        dataReg <= wrData[0 +: DATA_W];
        failReg <= 1'b0;
      end else begin
        if (strb.sample)              dataReg <= {dataReg[DATA_W-2:0], mdioIn};
        if (strb.taCheck && mdioIn)   failReg <= 1'b1;
      end
      if (cfgWr) begin
        c22Reg     <= wrData[C22_BIT];
        divVal     <= wrData[DIV_LSB +: DIV_W];
        noPreamble <= wrData[NOPRE_BIT];
      end
    end
  end

  // whole frame as it leaves the wire, first slot in the MSB
  assign frameImg = {{PRE_SLOTS{1'b1}}, 2'b01, opReg, phyReg, regReg, 2'b10, dataReg};
  assign frameBit = frameImg[SLOT_W'(FRAME_SLOTS - 1) - slot];

  always_comb begin
    cmdWord                        = '0;
    cmdWord[START_BIT]             = running;
    cmdWord[FAIL_BIT]              = failReg;
    cmdWord[OP_LSB  +: OP_W]       = opReg;
    cmdWord[PHY_LSB +: PHY_W]      = phyReg;
    cmdWord[REG_LSB +: REG_W]      = regReg;
    cmdWord[0 +: DATA_W]           = dataReg;
    cfgWord                        = '0;
    cfgWord[C22_BIT]               = c22Reg;
    cfgWord[DIV_LSB +: DIV_W]      = divVal;
    cfgWord[NOPRE_BIT]             = noPreamble;
  end

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (running && cmdWr) |=> $stable({opReg, phyReg, regReg})); // R9
  AST_FAIL_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failReg) |-> (opReg == OP_READ)); // R7
endmodule

// File: rtl/mdio_host.sv
module mdio_host
  import mdio_pkg::*;
#(
  parameter int RST_DIV = 49,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  logic              cmdSel, cfgSel;
  logic              startPulse, startRead, noPreamble, running, frameBit;
  logic [DIV_W-1:0]  divVal;
  logic [SLOT_W-1:0] slot;
  logic [31:0]       cmdWord, cfgWord;
  strobe_t           strb;

  assign cmdSel = (regAddr == ADDR_W'(CMD_OFS));
  assign cfgSel = (regAddr == ADDR_W'(CFG_OFS));

  mdio_dp #(.RST_DIV(RST_DIV)) uDp (
    .clk(clk), .rstN(rstN),
    .cmdWr(regWrEn && cmdSel), .cfgWr(regWrEn && cfgSel),
    .wrData(regWrData), .running(running), .strb(strb), .slot(slot),
    .mdioIn(mdioIn), .startPulse(startPulse), .startRead(startRead),
    .divVal(divVal), .noPreamble(noPreamble), .frameBit(frameBit),
    .cmdWord(cmdWord), .cfgWord(cfgWord)
  );

  mdio_ctl uCtl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .divVal(divVal),
    .noPreamble(noPreamble), .startRead(startRead), .strb(strb),
    .slot(slot), .running(running), .mdc(mdc), .mdioOe(mdioOe)
  );

  assign mdioOut   = mdioOe & frameBit;
  assign regRdData = cmdSel ? cmdWord : (cfgSel ? cfgWord : 32'h0);

  AST_OUT_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe))); // R11
endmodule

// File: tb/sim_mdio_host.sv
module sim_mdio_host;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = 4'h0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  always #5 clk = ~clk;

  mdio_host u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int total = 0;
  int bad = 0;
  int cycCnt = 0;
  int riseCnt = 0;
  int base = 0;
  int r11Viol = 0;
  logic [63:0] respWord = '1;
  logic capOe [64];
  logic capOut [64];
  int   riseTime [64];
  logic pMdc = 1'b0, pOut = 1'b0, pOe = 1'b0;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  // capture line state just after each rising clock edge
  initial forever begin
    @(posedge mdc);
    #1;
    if (riseCnt < 64) begin
      capOe[riseCnt]    = mdioOe;
      capOut[riseCnt]   = mdioOut;
      riseTime[riseCnt] = cycCnt;
    end
    riseCnt = riseCnt + 1;
  end

  // model PHY: present the next slot's value after each falling edge
  initial forever begin
    @(negedge mdc);
    #1;
    if (base + riseCnt < 64) mdioIn = respWord[63 - (base + riseCnt)];
    else                     mdioIn = 1'b1;
  end

  // R11 monitor: no line change during a high phase
  initial forever begin
    @(negedge clk);
    if (mdc && pMdc && (mdioOut !== pOut || mdioOe !== pOe)) r11Viol = r11Viol + 1;
    pMdc = mdc; pOut = mdioOut; pOe = mdioOe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total = total + 1; bad = bad + 1;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runFrame(input int div, input bit noPre, input bit isRd,
                          input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] data, input logic [15:0] phyData,
                          input bit failDrive, input bit interfere);
    logic [1:0]  op;
    logic [63:0] expFrame;
    logic [31:0] word, alt;
    int n, startCyc, busyCnt, half;
    bit okHdr, okTail, okTime;
    op       = isRd ? 2'b10 : 2'b01;
    expFrame = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, data};
    base     = noPre ? 32 : 0;
    n        = 64 - base;
    half     = div + 1;
    respWord = {32'hFFFF_FFFF, 14'h3FFF, 1'b1, failDrive, phyData};
    mdioIn   = 1'b1;
    wrReg(4'h4, (noPre ? 32'h1000 : 32'h0) | (32'(div) << 4) | 32'h1);
    riseCnt = 0;
    word = {2'b00, 1'b1, 1'b0, op, phy, rg, data};
    alt  = {2'b00, 1'b1, 1'b0, ~op, ~phy, ~rg, ~data};
    wrReg(4'h0, word);
    startCyc = cycCnt;
    busyCnt  = 0;
    while (regRdData[29] && busyCnt < 20000) begin
      busyCnt = busyCnt + 1;
      if (interfere && busyCnt == 40) begin regWrData = alt; regWrEn = 1'b1; end
      else regWrEn = 1'b0;
      @(negedge clk);
    end
    regWrEn = 1'b0;
    check(busyCnt == n * 2 * half, "R2 busy length", busyCnt, n * 2 * half);
    okTime = (riseCnt == n) && (riseTime[0] == startCyc + half);
    for (int i = 1; i < n && i < 64; i++)
      if (riseTime[i] - riseTime[i-1] != 2 * half) okTime = 1'b0;
    check(okTime, "R3 clock edge timing", riseCnt, n);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R3 idle after frame", {mdc, mdioOe}, 0);
    okHdr = 1'b1; okTail = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (base + i < 46) begin
        if (capOe[i] !== 1'b1 || capOut[i] !== expFrame[63 - (base + i)]) okHdr = 1'b0;
      end else if (isRd) begin
        if (capOe[i] !== 1'b0) okTail = 1'b0;
      end else begin
        if (capOe[i] !== 1'b1 || capOut[i] !== expFrame[63 - (base + i)]) okTail = 1'b0;
      end
    end
    check(okHdr, noPre ? "R8 header without preamble" : "R4 preamble and header", okHdr, 1);
    if (isRd) begin
      check(okTail, "R6 line released on turnaround and data", okTail, 1);
      check(regRdData[15:0] == phyData, "R6 read data", regRdData[15:0], phyData);
      check(regRdData[28] == failDrive, "R7 turnaround fail flag", regRdData[28], failDrive);
    end else begin
      check(okTail, "R5 write turnaround and data", okTail, 1);
      check(regRdData[28] == 1'b0, "R7 no fail on write", regRdData[28], 0);
    end
    if (interfere)
      check(regRdData[27:16] == {op, phy, rg}, "R9 busy write ignored", regRdData[27:16], {op, phy, rg});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    regAddr = 4'h0; #1;
    check(regRdData == 32'h0, "R1 command reset", regRdData, 0);
    regAddr = 4'h4; #1;
    check(regRdData == 32'h311, "R1 config reset", regRdData, 32'h311);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R1 outputs reset", {mdc, mdioOe}, 0);
    @(negedge clk); rstN = 1'b1;

    // R12 configuration readback
    wrReg(4'h4, 32'hFFFF_FFFF); #1;
    check(regRdData == 32'h13F1, "R12 config all ones", regRdData, 32'h13F1);
    wrReg(4'h4, 32'h0000_0000); #1;
    check(regRdData == 32'h0, "R12 config zeros", regRdData, 0);
    wrReg(4'h4, 32'h0000_1025); #1;
    check(regRdData == 32'h1021, "R12 config mixed", regRdData, 32'h1021);

    // R10 store without start
    riseCnt = 0;
    wrReg(4'h0, 32'h0555_BEEF); #1;
    check(regRdData == 32'h0555_BEEF, "R10 fields stored no busy", regRdData, 32'h0555_BEEF);
    repeat (300) @(negedge clk);
    check(riseCnt == 0 && mdc == 1'b0, "R10 no frame started", riseCnt, 0);

    // sweep of divider, preamble mode and operation
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 2; p++)
        for (int r = 0; r < 2; r++) begin
          int k;
          k = d * 4 + p * 2 + r;
          runFrame(d, p[0], r[0], 5'(k * 7 + 3), 5'(k * 11 + 1),
                   16'((k * 4951) ^ 16'hA5C3), 16'(16'hFFFF - k * 3869),
                   (r == 1) && (d % 2 == 1), 1'b0);
        end

    runFrame(1, 1'b0, 1'b0, 5'h12, 5'h07, 16'h3C5A, 16'h0, 1'b0, 1'b1);  // R9
    runFrame(63, 1'b0, 1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0, 1'b0, 1'b0); // R3 max divider
    runFrame(49, 1'b1, 1'b1, 5'h00, 5'h01, 16'h0, 16'h8001, 1'b1, 1'b0);

    check(r11Viol == 0, "R11 line stable while clock high", r11Viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule